// File: doc/BRIEF.md
# Tamper Shield Control Slave

This block is the software-facing control point of an active tamper shield. It sits on a simple synchronous register bus with a write strobe, an 8-bit address, 8-bit write data and 8-bit read data. Through that bus, software does five things:

- loads the 128-bit cipher key;
- loads the 128-bit initialization value;
- turns the shield on or off;
- reads the sticky per-packet alarm status;
- programs a rate divider.

The cipher, the mesh drivers and the mesh comparator lie outside this block. The divider produces a clock-enable that paces keystream generation and checking, so the shield can run at a fraction of the system clock to save power. While the shield is enabled, the comparator's per-packet mismatch flags are captured on each clock-enable into a status register. The OR of that register drives a hardwired alarm line.

The key and the initialization value are each assembled from sixteen byte writes. A small sequencer per value checks that the bytes arrive at consecutive offsets, starting at offset 0. After the last byte it raises a one-cycle load strobe towards the cipher. The word outputs hold the assembled value and must be sampled in the strobe cycle. There is no back-pressure: the cipher must accept a strobe in any cycle. An out-of-order byte is still stored, but it cancels the pending load. The bus has no wait states, and reads are combinational from the address.

Top module: `shield_ctrl_slave`

## Requirements
- R1: After reset the shield is disabled, the divider value is 0, the alarm status is 0, and `alarm_irq`, `tick`, `key_load` and `iv_load` are low.
- R2: Byte writes to addresses 0x00..0x0F assemble the key: offset i holds key bits [8i+7:8i]. When offsets 0 to 15 are written in order, `key_load` is high for exactly one cycle, the cycle after the write to offset 15, and `key_word` then carries the assembled key.
- R3: Byte writes to 0x10..0x1F assemble the initialization value in the same way and raise `iv_load` for one cycle. Reading 0x10+i returns byte i of the stored value.
- R4: A key or IV byte write at any offset other than the next expected one cancels the sequence. No load strobe fires until a new sequence starts again at offset 0.
- R5: Bit 0 of the control register at 0x20 enables the shield. Reading 0x20 returns the enable in bit 0 and zeros above it.
- R6: The divider register at 0x22 holds N. While the shield is enabled, `tick` is high for one cycle in every N+1 cycles, starting N+1 cycles after the enabling write. A divider write restarts this count. While the shield is disabled, `tick` stays low.
- R7: Status register 0x21 (bits 4:0, one bit per mesh packet) ORs in `alarm_in` on every cycle in which the shield is enabled and `tick` is high. Bits stay set until software writes a 1 to them. `alarm_in` has no effect while the shield is disabled.
- R8: `alarm_irq` is high exactly when any status bit is set, and it rises only after a cycle in which the shield was enabled and ticking.
- R9: Reads of the key addresses 0x00..0x0F and of every unmapped address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one write per high cycle |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| alarm_in | input | 5 | Per-packet mismatch flags from the mesh comparator |
| key_word | output | 128 | Assembled cipher key |
| key_load | output | 1 | One-cycle key load strobe to the cipher |
| iv_word | output | 128 | Assembled initialization value |
| iv_load | output | 1 | One-cycle IV load strobe to the cipher |
| shield_en | output | 1 | Shield enable |
| tick | output | 1 | Clock-enable pacing keystream generation and checking |
| alarm_irq | output | 1 | Hardwired alarm line, OR of status |

## Verification
The bench goes after the following corner cases:

- **Sequencing.** An interrupted key sequence must produce no strobe at all, and a restart at offset 0 must still complete normally. A sequencer that ignored ordering would emit a stray strobe, which the scoreboard flags as unexpected.
- **Divider edges.** With N=0 the tick must be high on every cycle. With N=3 the bench counts exactly one tick per four cycles over a fixed window, and a disabled shield must show no ticks. An off-by-one counter changes those counts.
- **Alarm status.** Alarm flags presented while the shield is disabled must leave the status at zero. Captured bits must survive a later all-clear input, and write-one-to-clear must clear only the written bits. A latch that sampled without the enable, or cleared on a zero input, reads back a wrong value.
- **Reads.** The key bytes and an unmapped address must read as zero, while the IV bytes read back.

// File: rtl/shield_ctrl_pkg.sv
package shield_ctrl_pkg;
  // register map (8-bit address space)
  localparam logic [7:0] KEY_BASE  = 8'h00;
  localparam logic [7:0] IV_BASE   = 8'h10;
  localparam logic [7:0] CTRL_ADDR = 8'h20;
  localparam logic [7:0] STAT_ADDR = 8'h21;
  localparam logic [7:0] DIV_ADDR  = 8'h22;

  typedef enum logic [0:0] {LD_IDLE = 1'b0, LD_FILL = 1'b1} ld_state_e;
endpackage

// File: rtl/shield_byte_loader.sv
// Assembles a wide word from in-order byte writes and strobes it out.
module shield_byte_loader
  import shield_ctrl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int WORD_W = 128,
  parameter int IDX_W  = $clog2(WORD_W / DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [IDX_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wdata,
  output logic [WORD_W-1:0] word_q,
  output logic              load_o
);
  localparam int NBYTES = WORD_W / DATA_W;
  localparam logic [IDX_W-1:0] LAST_OFF = IDX_W'(NBYTES - 1);

  ld_state_e        st_q;
  logic [IDX_W-1:0] next_q;
  logic             load_q;

  // byte storage: every hit is stored, in order or not
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (wr_hit) begin
      for (int b = 0; b < NBYTES; b++) begin
        if (wr_off == IDX_W'(b)) word_q[b*DATA_W +: DATA_W] <= wdata;
      end
    end
  end

  // ordering sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LD_IDLE;
      next_q <= '0;
      load_q <= 1'b0;
    end else begin
      load_q <= 1'b0;
      if (wr_hit) begin
        if (wr_off == '0) begin
          st_q   <= LD_FILL;
          next_q <= IDX_W'(1);
        end else if (st_q == LD_FILL && wr_off == next_q) begin
          if (wr_off == LAST_OFF) begin
            load_q <= 1'b1;
            st_q   <= LD_IDLE;
            next_q <= '0;
          end else begin
            next_q <= next_q + IDX_W'(1);
          end
        end else begin
          st_q   <= LD_IDLE;
          next_q <= '0;
        end
      end
    end
  end

  assign load_o = load_q;
endmodule

// File: rtl/shield_rate_div.sv
// Clock-enable generator: one pulse every DIV+1 cycles while running.
module shield_rate_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_n,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic             at_end;

  assign at_end = (cnt_q == div_n);
  assign tick   = run && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || restart || at_end) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/shield_alarm_latch.sv
// Sticky per-packet alarm capture with write-one-to-clear.
module shield_alarm_latch #(
  parameter int PACKETS = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sample,
  input  logic [PACKETS-1:0] alarm_in,
  input  logic               clr_wr,
  input  logic [PACKETS-1:0] clr_mask,
  output logic [PACKETS-1:0] status_q,
  output logic               any_alarm
);
  for (genvar p = 0; p < PACKETS; p++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        status_q[p] <= 1'b0;
      end else if (sample && alarm_in[p]) begin
        status_q[p] <= 1'b1;                // capture wins over clear
      end else if (clr_wr && clr_mask[p]) begin
        status_q[p] <= 1'b0;
      end
    end
  end

  assign any_alarm = |status_q;
endmodule

// File: rtl/shield_ctrl_slave.sv
module shield_ctrl_slave
  import shield_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 8,
  parameter int KEY_W   = 128,
  parameter int PACKETS = 5,
  parameter int DIV_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic [PACKETS-1:0] alarm_in,
  output logic [KEY_W-1:0]   key_word,
  output logic               key_load,
  output logic [KEY_W-1:0]   iv_word,
  output logic               iv_load,
  output logic               shield_en,
  output logic               tick,
  output logic               alarm_irq
);
  localparam int NBYTES = KEY_W / DATA_W;
  localparam int IDX_W  = $clog2(NBYTES);
  localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(KEY_BASE);
  localparam logic [ADDR_W-1:0] A_IV   = ADDR_W'(IV_BASE);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(DIV_ADDR);

  logic               in_key, in_iv;
  logic [ADDR_W-1:0]  key_rel, iv_rel;
  logic [IDX_W-1:0]   key_off, iv_off;
  logic               en_q;
  logic [DIV_W-1:0]   div_q;
  logic [PACKETS-1:0] stat_q;
  logic               div_wr, stat_wr, ctrl_wr;

  // address decode
  assign key_rel = addr - A_KEY;
  assign iv_rel  = addr - A_IV;
  assign in_key  = (addr >= A_KEY) && (key_rel < ADDR_W'(NBYTES));
  assign in_iv   = (addr >= A_IV)  && (iv_rel  < ADDR_W'(NBYTES));
  assign key_off = key_rel[IDX_W-1:0];
  assign iv_off  = iv_rel[IDX_W-1:0];
  assign ctrl_wr = wr_en && (addr == A_CTRL);
  assign stat_wr = wr_en && (addr == A_STAT);
  assign div_wr  = wr_en && (addr == A_DIV);

  shield_byte_loader #(.DATA_W(DATA_W), .WORD_W(KEY_W), .IDX_W(IDX_W)) u_key_ld (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_en && in_key), .wr_off(key_off),
    .wdata(wdata), .word_q(key_word), .load_o(key_load)
  );

  shield_byte_loader #(.DATA_W(DATA_W), .WORD_W(KEY_W), .IDX_W(IDX_W)) u_iv_ld (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_en && in_iv), .wr_off(iv_off),
    .wdata(wdata), .word_q(iv_word), .load_o(iv_load)
  );

  // control and divider registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      div_q <= '0;
    end else begin
      if (ctrl_wr) en_q  <= wdata[0];
      if (div_wr)  div_q <= DIV_W'(wdata);
    end
  end

  assign shield_en = en_q;

  shield_rate_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(en_q), .restart(div_wr),
    .div_n(div_q), .tick(tick)
  );

  shield_alarm_latch #(.PACKETS(PACKETS)) u_alarm (
    .clk(clk), .rst_n(rst_n), .sample(en_q && tick), .alarm_in(alarm_in),
    .clr_wr(stat_wr), .clr_mask(wdata[PACKETS-1:0]),
    .status_q(stat_q), .any_alarm(alarm_irq)
  );

  // read mux; key bytes and unmapped addresses read zero
  always_comb begin
    rdata = '0;
    if (in_iv) begin
      rdata = iv_word[iv_off*DATA_W +: DATA_W];
    end else if (addr == A_CTRL) begin
      rdata = DATA_W'(en_q);
    end else if (addr == A_STAT) begin
      rdata = DATA_W'(stat_q);
    end else if (addr == A_DIV) begin
      rdata = DATA_W'(div_q);
    end
  end
endmodule

// File: rtl/shield_ctrl_sva.sv
module shield_ctrl_sva #(
  parameter int ADDR_W  = 8,
  parameter int PACKETS = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  addr,
  input logic               shield_en,
  input logic               tick,
  input logic               key_load,
  input logic               iv_load,
  input logic               alarm_irq,
  input logic [PACKETS-1:0] alarm_status
);
  localparam logic [ADDR_W-1:0] LAST_KEY = ADDR_W'(8'h0F);
  localparam logic [ADDR_W-1:0] LAST_IV  = ADDR_W'(8'h1F);
  localparam logic [ADDR_W-1:0] STAT_A   = ADDR_W'(8'h21);

  assert_key_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    key_load |=> !key_load);

  assert_key_after_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    key_load |-> $past(wr_en && addr == LAST_KEY));

  assert_iv_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    iv_load |=> !iv_load);

  assert_iv_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    iv_load |-> $past(wr_en && addr == LAST_IV));

  assert_no_tick_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !shield_en |-> !tick);

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == STAT_A) |=>
      ((alarm_status & $past(alarm_status)) == $past(alarm_status)));

  assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_irq) |-> $past(shield_en && tick));
endmodule

bind shield_ctrl_slave shield_ctrl_sva #(.ADDR_W(ADDR_W), .PACKETS(PACKETS)) u_sva (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .shield_en(shield_en),
  .tick(tick), .key_load(key_load), .iv_load(iv_load), .alarm_irq(alarm_irq),
  .alarm_status(stat_q)
);

// File: tb/tb_shield_ctrl_slave.sv
module tb_shield_ctrl_slave;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [7:0]   addr = '0;
  logic [7:0]   wdata = '0;
  logic [7:0]   rdata;
  logic [4:0]   alarm_in = '0;
  logic [127:0] key_word, iv_word;
  logic         key_load, iv_load, shield_en, tick, alarm_irq;

  int total = 0;
  int bad = 0;
  int strobes = 0;

  typedef struct {bit is_iv; logic [127:0] val;} exp_t;
  exp_t sb_q[$];

  always #10 clk = ~clk; // 50 MHz

  shield_ctrl_slave dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .alarm_in(alarm_in), .key_word(key_word), .key_load(key_load),
    .iv_word(iv_word), .iv_load(iv_load), .shield_en(shield_en), .tick(tick),
    .alarm_irq(alarm_irq)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    check(req, {120'd0, rdata}, {120'd0, exp});
  endtask

  function automatic logic [7:0] kbyte(input int seed, input int i);
    return 8'(seed + i * 37) ^ 8'h5A;
  endfunction

  // driver: full in-order load, pushing the expected word into the scoreboard
  task automatic load_word(input bit is_iv, input int seed);
    exp_t e;
    e.is_iv = is_iv;
    for (int i = 0; i < 16; i++) e.val[i*8 +: 8] = kbyte(seed, i);
    sb_q.push_back(e);
    for (int i = 0; i < 16; i++) wr((is_iv ? 8'h10 : 8'h00) + 8'(i), kbyte(seed, i));
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && (key_load || iv_load)) begin
      strobes++;
      if (sb_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R4 unexpected strobe actual=%b%b expected=00", key_load, iv_load);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.is_iv ? "R3 iv strobe" : "R2 key strobe",
              {126'd0, key_load, iv_load}, {126'd0, !e.is_iv, e.is_iv});
        check(e.is_iv ? "R3 iv word" : "R2 key word",
              e.is_iv ? iv_word : key_word, e.val);
      end
    end
  end

  task automatic count_ticks(input int cycles, output int n);
    n = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (tick) n++;
    end
  endtask

  initial begin : watchdog
    #(20 * 100000);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int n;
    int s0;
    @(negedge clk); @(negedge clk);
    // R1 reset state
    check("R1 outputs", {122'd0, shield_en, tick, key_load, iv_load, alarm_irq, 1'b0}, '0);
    rst_n = 1'b1;
    rd_chk("R1 div", 8'h22, 8'h00);
    rd_chk("R1 status", 8'h21, 8'h00);
    rd_chk("R5 ctrl reset", 8'h20, 8'h00);

    // R2 / R3 normal loads
    load_word(1'b0, 11);
    load_word(1'b1, 90);
    repeat (2) @(negedge clk);
    check("R2 strobe count", 128'(strobes), 128'd2);
    rd_chk("R3 iv readback", 8'h15, kbyte(90, 5));
    rd_chk("R3 iv readback last", 8'h1F, kbyte(90, 15));
    rd_chk("R9 key write-only", 8'h03, 8'h00);
    rd_chk("R9 unmapped", 8'h40, 8'h00);

    // R4 aborted sequence: skip offset 8
    s0 = strobes;
    for (int i = 0; i < 8; i++) wr(8'(i), 8'hEE);
    for (int i = 9; i < 16; i++) wr(8'(i), 8'hEE);
    repeat (2) @(negedge clk);
    check("R4 no strobe on gap", 128'(strobes), 128'(s0));
    load_word(1'b0, 200);   // restart from offset 0 still works
    repeat (2) @(negedge clk);
    check("R4 restart strobes", 128'(strobes), 128'(s0 + 1));

    // R6 disabled: no ticks
    count_ticks(20, n);
    check("R6 no tick disabled", 128'(n), 128'd0);

    // R7 alarm ignored while disabled
    @(negedge clk); alarm_in = 5'b11111;
    repeat (3) @(negedge clk); alarm_in = '0;
    rd_chk("R7 ignore disabled", 8'h21, 8'h00);
    check("R8 irq low", {127'd0, alarm_irq}, 128'd0);

    // R6 divider N=3
    wr(8'h22, 8'd3);
    rd_chk("R6 div readback", 8'h22, 8'd3);
    @(negedge clk); wr_en = 1'b1; addr = 8'h20; wdata = 8'h01;
    @(negedge clk); wr_en = 1'b0;
    // enabling edge passed: first tick on 4th sample
    n = 0;
    if (tick) n++;
    begin
      int m;
      count_ticks(39, m);
      n += m;
    end
    check("R6 ticks N=3", 128'(n), 128'd10);
    rd_chk("R5 ctrl enabled", 8'h20, 8'h01);

    // R6 N=0: every cycle
    wr(8'h22, 8'd0);
    count_ticks(10, n);
    check("R6 ticks N=0", 128'(n), 128'd10);

    // R7 capture with tick every cycle
    @(negedge clk); alarm_in = 5'b00100;
    @(negedge clk); alarm_in = 5'b00000;
    rd_chk("R7 capture", 8'h21, 8'h04);
    @(negedge clk); alarm_in = 5'b10001;
    @(negedge clk); alarm_in = 5'b00000;
    repeat (3) @(negedge clk);
    rd_chk("R7 sticky", 8'h21, 8'h15);
    check("R8 irq high", {127'd0, alarm_irq}, 128'd1);
    wr(8'h21, 8'h04);
    rd_chk("R7 w1c partial", 8'h21, 8'h11);
    wr(8'h21, 8'h11);
    rd_chk("R7 w1c all", 8'h21, 8'h00);
    check("R8 irq cleared", {127'd0, alarm_irq}, 128'd0);

    // R5 disable stops ticking
    wr(8'h20, 8'h00);
    count_ticks(8, n);
    check("R5 disable stops tick", 128'(n), 128'd0);
    check("R5 shield_en low", {127'd0, shield_en}, 128'd0);
    check("R2 scoreboard drained", 128'(sb_q.size()), 128'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule